// File: doc/BRIEF.md
# Infrared Run-Length Carrier Transmitter

This block turns a stream of run-length samples into the drive signals for up to two infrared emitters. Software places each sample, a mark/space flag above a duration field counted in sample periods, into one of two holding slots that are used alternately. Once transmission is enabled, the block plays the slots back in strict alternation, starting from slot 0. Each time it takes a sample out of a slot it raises a one-cycle interrupt, so software can refill the slot that has just been emptied while the other slot is playing.

During a mark the output is chopped by a carrier. The carrier period and its active width are counted in ticks of 500 ns, and a polarity control inverts the waveform. When the carrier is disabled, or the programmed period is zero, a mark drives the emitters steadily. When a sample ends and the next slot is still empty, the emitters go dark, an underrun flag is raised and one more interrupt fires. That interrupt marks the end of the burst. A two-bit emitter mask, accepted only when it holds a legal value, selects which emitter outputs follow the modulated signal.

Top module: `ir_tx_runlen`

## Requirements
- R1: After reset the emitters are low, `irq`, `underrun` and `busy` are low, and the emitter mask is 2'b11.
- R2: While `tx_en` is high and the block is idle, the block loads slot 0 first if that slot holds a sample. After that it alternates 1, 0, 1 and so on. Every load raises `irq` for exactly one cycle, in the first cycle of the new sample.
- R3: A sample plays for D × SAMPLE_TICKS × TICK_DIV clock cycles, where D is bits [DUR_W-1:0] of the sample and a value of 0 counts as 1. If the next slot is full, its sample starts in the very next cycle.
- R4: A sample with bit DUR_W (the mark flag) clear is a space, and both emitters stay low for its whole length.
- R5: During a mark, with `car_en` set and a nonzero `car_period`, the level in cycle k of the sample is ((k / TICK_DIV) mod car_period < H) XOR `car_pol`. H is `car_high`, or 1 when `car_high` is 0. The carrier phase restarts at every sample.
- R6: During a mark, with `car_en` clear or `car_period` equal to 0, the level is steadily high.
- R7: When a sample ends and the next slot is empty, `busy` falls and the emitters go low. In the same cycle `underrun` is set and `irq` pulses once. `underrun` is cleared by the next slot write.
- R8: A `mask_wr` with a `mask_in` that is nonzero and has bits [3:2] clear replaces the mask. Any other value is ignored. Emitter `emit[i]` can be high only when mask bit i is set.
- R9: While `tx_en` is low the block is idle, with `busy` low and the emitters low from the following cycle. The next burst starts again from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Enables playback; when low, aborts playback and resets the slot order |
| wr_en | input | 1 | Writes `wr_data` into the selected slot |
| wr_sel | input | 1 | Slot to write (0 or 1) |
| wr_data | input | DUR_W+1 | Sample: bit DUR_W is the mark flag, the low bits are the duration |
| car_en | input | 1 | Enables carrier modulation of marks |
| car_period | input | CAR_W | Carrier period in ticks |
| car_high | input | CAR_W | Carrier active width in ticks (0 acts as 1) |
| car_pol | input | 1 | Inverts the carrier waveform |
| mask_wr | input | 1 | Strobe to update the emitter mask |
| mask_in | input | 4 | Proposed emitter mask |
| emit | output | 2 | Emitter drive outputs |
| irq | output | 1 | One-cycle pulse on each sample load and at burst end |
| underrun | output | 1 | Set when playback ran out of samples |
| busy | output | 1 | A sample is playing |

## Verification
The bench builds the block with TICK_DIV = 2 and SAMPLE_TICKS = 4, so that one sample period lasts 8 cycles. With these values a mark at the full 127-period duration stays near a thousand cycles. It sweeps every carrier period from 1 to 4, every active width from 0 up to and past the period, and both polarities. It predicts each emitter level cycle by cycle from the tick arithmetic, so wrap points and the width-zero case are all compared. Separate runs cover the unmodulated cases, the rotating legal masks and rejected illegal masks, and an abort followed by a restart from slot 0.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
    localparam int EMIT_N    = 2;
    localparam int MASK_IN_W = 4;
    localparam int SLOT_N    = 2;

    function automatic logic mask_legal(input logic [MASK_IN_W-1:0] m);
        return (m != '0) && (m[MASK_IN_W-1:EMIT_N] == '0);
    endfunction
endpackage

// File: rtl/ir_tx_slots.sv
module ir_tx_slots
    import ir_tx_pkg::*;
#(
    parameter int SW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [SW-1:0]        wr_data,
    input  logic                 take,
    input  logic                 take_sel,
    output logic [SLOT_N-1:0]    full,
    output logic [SW-1:0]        rd_data
);
    typedef struct packed {
        logic [SLOT_N-1:0]         full;
        logic [SLOT_N-1:0][SW-1:0] data;
    } slot_st_t;

    slot_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < SLOT_N; i++) begin
            if (take && (take_sel == 1'(i))) s_d.full[i] = 1'b0;
            if (wr_en && (wr_sel == 1'(i))) begin
                s_d.full[i] = 1'b1;
                s_d.data[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign full    = s_q.full;
    assign rd_data = s_q.data[take_sel];
endmodule

// File: rtl/ir_tx_carrier.sv
module ir_tx_carrier #(
    parameter int CAR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic             mod_en,
    input  logic [CAR_W-1:0] period,
    input  logic [CAR_W-1:0] high,
    input  logic             pol,
    output logic             level
);
    typedef struct packed {
        logic [CAR_W-1:0] phase;
    } car_st_t;

    car_st_t s_d, s_q;
    logic [CAR_W-1:0] high_eff;

    always_comb begin
        s_d = s_q;
        if (restart) begin
            s_d.phase = '0;
        end else if (tick) begin
            if (s_q.phase >= CAR_W'(period - 1'b1)) s_d.phase = '0;
            else                                     s_d.phase = s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign high_eff = (high == '0) ? CAR_W'(1) : high;
    assign level    = mod_en ? ((s_q.phase < high_eff) ^ pol) : 1'b1;
endmodule

// File: rtl/ir_tx_mask.sv
module ir_tx_mask
    import ir_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [MASK_IN_W-1:0] value,
    output logic [EMIT_N-1:0]    mask
);
    typedef struct packed {
        logic [EMIT_N-1:0] mask;
    } mask_st_t;

    mask_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr && mask_legal(value)) s_d.mask = value[EMIT_N-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.mask <= '1;
        else        s_q      <= s_d;
    end

    assign mask = s_q.mask;
endmodule

// File: rtl/ir_tx_runlen.sv
module ir_tx_runlen
    import ir_tx_pkg::*;
#(
    parameter int TICK_DIV     = 100,
    parameter int SAMPLE_TICKS = 100,
    parameter int DUR_W        = 7,
    parameter int CAR_W        = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_en,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [DUR_W:0]       wr_data,
    input  logic                 car_en,
    input  logic [CAR_W-1:0]     car_period,
    input  logic [CAR_W-1:0]     car_high,
    input  logic                 car_pol,
    input  logic                 mask_wr,
    input  logic [3:0]           mask_in,
    output logic [1:0]           emit,
    output logic                 irq,
    output logic                 underrun,
    output logic                 busy
);
    localparam int SW    = DUR_W + 1;
    localparam int TD_W  = $clog2(TICK_DIV + 1);
    localparam int ST_W  = $clog2(SAMPLE_TICKS + 1);
    localparam logic [TD_W-1:0] LAST_PRE = TD_W'(TICK_DIV - 1);
    localparam logic [ST_W-1:0] LAST_SUB = ST_W'(SAMPLE_TICKS - 1);

    typedef struct packed {
        logic             active;
        logic             pulse;
        logic [DUR_W-1:0] dur;
        logic [ST_W-1:0]  sub;
        logic [TD_W-1:0]  pre;
        logic             ptr;
        logic             underrun;
        logic             irq;
    } seq_st_t;

    seq_st_t s_d, s_q;

    logic [SLOT_N-1:0] full;
    logic [SW-1:0]     rd_data;
    logic [EMIT_N-1:0] mask_q;
    logic              load;
    logic              tick;
    logic              sub_end;
    logic              smp_end;
    logic              car_level;
    logic              cur_pulse;
    logic              drive;
    logic [DUR_W-1:0]  new_dur;

    ir_tx_slots #(.SW(SW)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .take     (load),
        .take_sel (s_q.ptr),
        .full     (full),
        .rd_data  (rd_data)
    );

    ir_tx_mask u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (mask_wr),
        .value (mask_in),
        .mask  (mask_q)
    );

    ir_tx_carrier #(.CAR_W(CAR_W)) u_car (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .tick    (tick),
        .mod_en  (car_en && (car_period != '0)),
        .period  (car_period),
        .high    (car_high),
        .pol     (car_pol),
        .level   (car_level)
    );

    assign tick    = s_q.active && (s_q.pre == LAST_PRE);
    assign sub_end = tick && (s_q.sub == LAST_SUB);
    assign smp_end = sub_end && (s_q.dur <= DUR_W'(1));
    assign new_dur = (rd_data[DUR_W-1:0] == '0) ? DUR_W'(1) : rd_data[DUR_W-1:0];

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        load    = 1'b0;
        if (wr_en) s_d.underrun = 1'b0;

        if (!tx_en) begin
            s_d.active = 1'b0;
            s_d.ptr    = 1'b0;
            s_d.pre    = '0;
            s_d.sub    = '0;
        end else if (!s_q.active || smp_end) begin
            if (full[s_q.ptr]) begin
                load       = 1'b1;
                s_d.active = 1'b1;
                s_d.pulse  = rd_data[DUR_W];
                s_d.dur    = new_dur;
                s_d.pre    = '0;
                s_d.sub    = '0;
                s_d.ptr    = ~s_q.ptr;
                s_d.irq    = 1'b1;
            end else if (s_q.active) begin
                s_d.active   = 1'b0;
                s_d.underrun = 1'b1;
                s_d.irq      = 1'b1;
            end
        end else begin
            s_d.pre = tick ? '0 : s_q.pre + 1'b1;
            if (sub_end) begin
                s_d.sub = '0;
                s_d.dur = s_q.dur - 1'b1;
            end else if (tick) begin
                s_d.sub = s_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_pulse = s_q.pulse;
    assign drive     = s_q.active & cur_pulse & car_level;

    for (genvar g = 0; g < EMIT_N; g++) begin : g_emit
        assign emit[g] = mask_q[g] & drive;
    end

    assign irq      = s_q.irq;
    assign underrun = s_q.underrun;
    assign busy     = s_q.active;
endmodule

// File: rtl/ir_tx_runlen_chk.sv
module ir_tx_runlen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_en,
    input logic       busy,
    input logic       irq,
    input logic       underrun,
    input logic [1:0] emit,
    input logic [1:0] mask_q,
    input logic       cur_pulse
);
    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (emit == 2'b00)); // R7
    AST_SPACE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cur_pulse) |-> (emit == 2'b00)); // R4
    AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((emit & ~mask_q) == 2'b00)); // R8
    AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q != 2'b00)); // R8
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !busy); // R9
    AST_LOAD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> irq); // R2
    AST_UNDERRUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> (!busy && irq)); // R7
endmodule

bind ir_tx_runlen ir_tx_runlen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .busy      (busy),
    .irq       (irq),
    .underrun  (underrun),
    .emit      (emit),
    .mask_q    (mask_q),
    .cur_pulse (cur_pulse)
);

// File: tb/sim_ir_tx_runlen.sv
module sim_ir_tx_runlen;
    localparam int TD = 2;
    localparam int ST = 4;
    localparam int DW = 7;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_en = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [DW:0]   wr_data = '0;
    logic          car_en = 1'b1;
    logic [CW-1:0] car_period = CW'(3);
    logic [CW-1:0] car_high = CW'(1);
    logic          car_pol = 1'b0;
    logic          mask_wr = 1'b0;
    logic [3:0]    mask_in = 4'd0;
    logic [1:0]    emit;
    logic          irq;
    logic          underrun;
    logic          busy;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    logic [DW:0] seq [6];

    always #2.5 clk = ~clk;

    ir_tx_runlen #(.TICK_DIV(TD), .SAMPLE_TICKS(ST), .DUR_W(DW), .CAR_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .car_en(car_en), .car_period(car_period),
        .car_high(car_high), .car_pol(car_pol), .mask_wr(mask_wr),
        .mask_in(mask_in), .emit(emit), .irq(irq), .underrun(underrun), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_emit(input logic p, input int k, input logic [1:0] m);
        logic lvl;
        int   ph;
        int   h;
        if (!p) lvl = 1'b0;
        else if (!car_en || car_period == '0) lvl = 1'b1;
        else begin
            ph  = (k / TD) % int'(car_period);
            h   = (car_high == '0) ? 1 : int'(car_high);
            lvl = ((ph < h) ? 1'b1 : 1'b0) ^ car_pol;
        end
        return m & {lvl, lvl};
    endfunction

    task automatic put(input logic sel, input logic [DW:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mask(input logic [3:0] v);
        @(negedge clk);
        mask_wr = 1'b1; mask_in = v;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic run_seq(input logic [1:0] m);
        int dur;
        string tag;
        @(negedge clk);
        tx_en = 1'b0;
        put(1'b0, seq[0]);
        put(1'b1, seq[1]);
        check("R7 underrun cleared by write", int'(underrun), 0);
        tx_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            dur = (seq[i][DW-1:0] == '0) ? 1 : int'(seq[i][DW-1:0]);
            for (int k = 0; k < dur * ST * TD; k++) begin
                @(negedge clk);
                if (k == 0) begin
                    check("R2 irq on load", int'(irq), 1);
                    check("R3 busy during sample", int'(busy), 1);
                    if (i + 2 < 6) begin
                        wr_en = 1'b1; wr_sel = 1'(i % 2); wr_data = seq[i + 2];
                    end
                end
                if (k == 1) begin
                    wr_en = 1'b0;
                    check("R2 irq one cycle", int'(irq), 0);
                end
                if (!seq[i][DW]) tag = "R4 space level";
                else if (!car_en || car_period == '0) tag = "R6 steady mark";
                else tag = "R5 carrier level";
                check(tag, int'(emit), int'(exp_emit(seq[i][DW], k, m)));
            end
        end
        @(negedge clk);
        check("R7 busy low at end", int'(busy), 0);
        check("R7 underrun set", int'(underrun), 1);
        check("R7 final irq", int'(irq), 1);
        check("R7 emit dark", int'(emit), 0);
        @(negedge clk);
        check("R7 final irq single", int'(irq), 0);
        tx_en = 1'b0;
    endtask

    initial begin
        seq[0] = {1'b1, 7'd5};
        seq[1] = {1'b0, 7'd2};
        seq[2] = {1'b1, 7'd0};
        seq[3] = {1'b0, 7'd1};
        seq[4] = {1'b1, 7'd127};
        seq[5] = {1'b0, 7'd3};
        repeat (3) @(negedge clk);
        check("R1 reset emit", int'(emit), 0);
        check("R1 reset irq", int'(irq), 0);
        check("R1 reset underrun", int'(underrun), 0);
        check("R1 reset busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", int'(busy), 0);
        // R1: default mask 2'b11 seen through the emitters
        run_seq(2'b11);

        for (int p = 1; p <= 4; p++) begin
            for (int h = 0; h <= p + 1; h++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    logic [1:0] m;
                    m = 2'(((p + h + pol) % 3) + 1);
                    car_en = 1'b1; car_period = CW'(p); car_high = CW'(h);
                    car_pol = 1'(pol);
                    set_mask({2'b00, m});
                    run_seq(m);
                end
            end
        end

        // R6: carrier disabled, then zero period with carrier enabled
        car_period = CW'(3); car_high = CW'(1); car_pol = 1'b0; car_en = 1'b0;
        set_mask(4'b0011);
        run_seq(2'b11);
        car_en = 1'b1; car_period = '0;
        run_seq(2'b11);

        // R8: illegal masks are ignored
        car_period = CW'(2); car_high = CW'(1);
        set_mask(4'b0001);
        set_mask(4'b0000);
        set_mask(4'b0101);
        set_mask(4'b1000);
        run_seq(2'b01);

        // R9: abort mid-burst, then restart from slot 0
        put(1'b0, seq[0]);
        put(1'b1, seq[1]);
        tx_en = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 busy while playing", int'(busy), 1);
        tx_en = 1'b0;
        @(negedge clk);
        check("R9 busy low after stop", int'(busy), 0);
        check("R9 emit dark after stop", int'(emit), 0);
        repeat (4) @(negedge clk);
        check("R9 stays idle", int'(busy), 0);
        run_seq(2'b01);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule